// File: doc/BRIEF.md
# Counter-Based Watchdog Timer

This block is a supervisory timer that asks for a system reset when software stops servicing it. A free-running counter advances on every cycle in which a counter clock enable is high. The counter is split into a low part and a high part. Software services the timer by writing an offset, and the block stores a deadline equal to the current high part plus that offset, wrapping at the width of the high part. When the low part rolls over and carries the high part onto the deadline, the block raises its reset output for one cycle.

Each offset unit is therefore one full turn of the low part of the counter. With the default widths that is 256 counter clocks. The first expiry happens between one unit less than the offset and the full offset after the service write. A mode write sets an enable flag and a lock flag. The timer comes out of reset enabled, unlocked and armed with a built-in offset. After the lock is set, the timer cannot be turned off again until the next system reset.

Top module: `tick_watchdog`

## Requirements
- R1: The counter advances only in cycles where `cntEn` is high. While `cntEn` is low, no timeout can occur.
- R2: A service write (`kickWr` high) stores the deadline `(high part + kickData) mod 2^OFFSET_W`. The high part is sampled in the same cycle. `wdReset` goes high in the cycle after the clock edge that carries the counter from (deadline−1, all ones in the low part) to (deadline, 0).
- R3: `wdReset` stays high for exactly one cycle. After a timeout the block stays disarmed and gives no further pulse until it is serviced again or re-enabled.
- R4: If service writes keep arriving closer together than the timeout, `wdReset` never rises. When they stop, exactly one pulse follows.
- R5: An offset of zero gives a full span of 2^OFFSET_W units, which is one complete turn of the counter.
- R6: A service write in the same cycle as the rollover onto the old deadline takes priority. No pulse is produced, and the new deadline applies.
- R7: After reset, `wdReset` is 0, `wdEnabled` is 1 and `wdLocked` is 0. The counter starts at zero and the block is armed with deadline INIT_OFFSET.
- R8: While unlocked, a mode write (`cfgWr`) with `cfgEnable` = 0 clears `wdEnabled`. While disabled, no pulse is produced, even after a service write.
- R9: A mode write that turns the timer from disabled to enabled stores the deadline `(high part + INIT_OFFSET) mod 2^OFFSET_W` and arms the block.
- R10: A mode write with `cfgLock` = 1 sets `wdLocked` until the next reset and forces `wdEnabled` to 1. While locked, a mode write with `cfgEnable` = 0 leaves `wdEnabled` at 1.
- R11: The deadline sum wraps modulo 2^OFFSET_W. A service write near the top of the high part sets a deadline after the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| cntEn | input | 1 | Counter clock enable |
| kickWr | input | 1 | Service write strobe |
| kickData | input | OFFSET_W | Timeout offset, in units of one low-part turn |
| cfgWr | input | 1 | Mode write strobe |
| cfgEnable | input | 1 | Enable value for a mode write |
| cfgLock | input | 1 | Lock request for a mode write |
| wdReset | output | 1 | One-cycle reset request |
| wdEnabled | output | 1 | Current enable flag |
| wdLocked | output | 1 | Current lock flag |

## Verification
The bench builds the block with CNT_W = 10, OFFSET_W = 4 and INIT_OFFSET = 3. With these values one unit is 64 clocks and the whole counter turns every 1024 clocks. This makes several cases short enough to test directly:
- the wrap of the deadline sum,
- the offset-zero full turn,
- the service write that lands exactly on the rollover edge,
- the repeated-pulse check over a full counter turn.

A reference counter in the bench predicts the edge of each expected pulse from the counter value at the service write.

// File: rtl/tick_wdog_pkg.sv
package tick_wdog_pkg;

  // Load requests from the control section to the datapath.
  typedef struct packed {
    logic loadKick;   // deadline <= high part + service offset
    logic loadInit;   // deadline <= high part + built-in offset
  } wdogStrobe_t;

endpackage

// File: rtl/tick_wdog_dp.sv
module tick_wdog_dp
  import tick_wdog_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int OFFSET_W    = 8,
  parameter int INIT_OFFSET = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cntEn,
  input  wdogStrobe_t         strobe,
  input  logic [OFFSET_W-1:0] kickData,
  output logic                hitNext,
  output logic [CNT_W-1:0]    cntValue
);

  localparam int LOW_W = CNT_W - OFFSET_W;
  localparam logic [LOW_W-1:0]    LOW_ONE = 1;
  localparam logic [OFFSET_W-1:0] HI_ONE  = 1;
  localparam logic [OFFSET_W-1:0] INIT_HI = INIT_OFFSET[OFFSET_W-1:0];

  logic [LOW_W-1:0]    cntLow;
  logic [OFFSET_W-1:0] cntHigh;
  logic [OFFSET_W-1:0] matchHi;
  logic                lowWrap;
  logic [OFFSET_W-1:0] highNext;

  assign lowWrap  = &cntLow;
  assign highNext = cntHigh + HI_ONE;

  // Free-running split counter; the high part steps on each low rollover.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntLow  <= '0;
      cntHigh <= '0;
    end else if (cntEn) begin
      cntLow <= cntLow + LOW_ONE;
      if (lowWrap) cntHigh <= highNext;
    end
  end

  // Deadline register; the service write takes precedence over re-enable.
  always_ff @(posedge clk) begin
    if (!rstN)                matchHi <= INIT_HI;
    else if (strobe.loadKick) matchHi <= cntHigh + kickData;
    else if (strobe.loadInit) matchHi <= cntHigh + INIT_HI;
  end

  // True on the edge that carries the counter onto the deadline.
  assign hitNext  = cntEn & lowWrap & (highNext == matchHi);
  assign cntValue = {cntHigh, cntLow};

endmodule

// File: rtl/tick_wdog_ctrl.sv
module tick_wdog_ctrl
  import tick_wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        kickWr,
  input  logic        cfgWr,
  input  logic        cfgEnable,
  input  logic        cfgLock,
  input  logic        hitNext,
  output wdogStrobe_t strobe,
  output logic        wdReset,
  output logic        wdEnabled,
  output logic        wdLocked
);

  logic enabled;
  logic locked;
  logic armed;
  logic enNext;
  logic lockNext;
  logic fire;

  always_comb begin
    lockNext = locked | (cfgWr & cfgLock);
    enNext   = enabled;
    if (cfgWr) enNext = lockNext ? 1'b1 : cfgEnable;
    strobe.loadKick = kickWr;
    strobe.loadInit = enNext & ~enabled;
    fire = enabled & armed & hitNext & ~kickWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabled <= 1'b1;
      locked  <= 1'b0;
      armed   <= 1'b1;
      wdReset <= 1'b0;
    end else begin
      enabled <= enNext;
      locked  <= lockNext;
      wdReset <= fire;
      if (kickWr | strobe.loadInit) armed <= 1'b1;
      else if (fire)                armed <= 1'b0;
    end
  end

  assign wdEnabled = enabled;
  assign wdLocked  = locked;

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import tick_wdog_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int OFFSET_W    = 8,
  parameter int INIT_OFFSET = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cntEn,
  input  logic                kickWr,
  input  logic [OFFSET_W-1:0] kickData,
  input  logic                cfgWr,
  input  logic                cfgEnable,
  input  logic                cfgLock,
  output logic                wdReset,
  output logic                wdEnabled,
  output logic                wdLocked
);

  wdogStrobe_t      strobe;
  logic             hitNext;
  logic [CNT_W-1:0] cntValue;

  tick_wdog_dp #(
    .CNT_W(CNT_W), .OFFSET_W(OFFSET_W), .INIT_OFFSET(INIT_OFFSET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .strobe(strobe),
    .kickData(kickData), .hitNext(hitNext), .cntValue(cntValue)
  );

  tick_wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .kickWr(kickWr), .cfgWr(cfgWr),
    .cfgEnable(cfgEnable), .cfgLock(cfgLock), .hitNext(hitNext),
    .strobe(strobe), .wdReset(wdReset), .wdEnabled(wdEnabled),
    .wdLocked(wdLocked)
  );

endmodule

// File: rtl/tick_wdog_chk.sv
module tick_wdog_chk #(
  parameter int LOW_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEn,
  input logic             kickWr,
  input logic             wdReset,
  input logic             wdEnabled,
  input logic             wdLocked,
  input logic [LOW_W-1:0] cntLow
);

  assert_frozen_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> !wdReset);

  assert_pulse_on_rollover_R2: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> (cntLow == '0));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |=> !wdReset);

  assert_kick_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    kickWr |=> !wdReset);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnabled |=> !wdReset);

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    wdLocked |=> wdLocked);

  assert_lock_forces_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    wdLocked |-> wdEnabled);

endmodule

bind tick_watchdog tick_wdog_chk #(.LOW_W(CNT_W - OFFSET_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntEn(cntEn), .kickWr(kickWr),
  .wdReset(wdReset), .wdEnabled(wdEnabled), .wdLocked(wdLocked),
  .cntLow(cntValue[CNT_W-OFFSET_W-1:0])
);

// File: tb/tick_watchdog_tb.sv
module tick_watchdog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int OFFSET_W   = 4;
  localparam int INIT_OFF   = 3;
  localparam int LOW_W      = CNT_W - OFFSET_W;
  localparam int UNIT       = 1 << LOW_W;
  localparam int HI_SPAN    = 1 << OFFSET_W;
  localparam int CNT_SPAN   = 1 << CNT_W;
  localparam int WATCHDOG   = 200000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                cntEn = 1'b1;
  logic                kickWr = 1'b0;
  logic [OFFSET_W-1:0] kickData = '0;
  logic                cfgWr = 1'b0;
  logic                cfgEnable = 1'b0;
  logic                cfgLock = 1'b0;
  logic                wdReset;
  logic                wdEnabled;
  logic                wdLocked;

  int checks = 0;
  int errors = 0;
  int benchCnt = 0;
  int cycles = 0;

  tick_watchdog #(
    .CNT_W(CNT_W), .OFFSET_W(OFFSET_W), .INIT_OFFSET(INIT_OFF)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .kickWr(kickWr),
    .kickData(kickData), .cfgWr(cfgWr), .cfgEnable(cfgEnable),
    .cfgLock(cfgLock), .wdReset(wdReset), .wdEnabled(wdEnabled),
    .wdLocked(wdLocked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference counter, built from R1 and R7.
  always @(posedge clk) begin
    if (!rstN) benchCnt <= 0;
    else if (cntEn) benchCnt <= (benchCnt + 1) % CNT_SPAN;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Edges from now until the counter reaches (match, 0).
  function automatic int edgesTo(input int match);
    int e;
    e = ((match * UNIT - benchCnt) % CNT_SPAN + CNT_SPAN) % CNT_SPAN;
    if (e == 0) e = CNT_SPAN;
    return e;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic doKick(input int off, output int expMatch);
    expMatch = ((benchCnt / UNIT) + off) % HI_SPAN;
    kickWr = 1'b1;
    kickData = off[OFFSET_W-1:0];
    @(posedge clk); @(negedge clk);
    kickWr = 1'b0;
  endtask

  task automatic doCfg(input bit en, input bit lk, output int hiAtWrite);
    hiAtWrite = benchCnt / UNIT;
    cfgWr = 1'b1; cfgEnable = en; cfgLock = lk;
    @(posedge clk); @(negedge clk);
    cfgWr = 1'b0; cfgEnable = 1'b0; cfgLock = 1'b0;
  endtask

  task automatic waitPulse(input int expEdges, input string tag);
    int seen;
    seen = 0;
    for (int n = 1; n <= expEdges + 4; n++) begin
      @(posedge clk); @(negedge clk);
      if (wdReset) begin
        seen = n;
        break;
      end
    end
    check(seen == expEdges, tag, seen, expEdges);
    @(posedge clk); @(negedge clk);
    check(wdReset == 1'b0, {tag, " one-cycle width R3"}, int'(wdReset), 0);
  endtask

  task automatic watchQuiet(input int n, input string tag);
    int hits;
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdReset) hits++;
    end
    check(hits == 0, tag, hits, 0);
  endtask

  task automatic doReset();
    rstN = 1'b0; cntEn = 1'b1;
    idle(3);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    idle(3);
    check(wdReset == 1'b0, "R7 reset pulse low", int'(wdReset), 0);
    check(wdEnabled == 1'b1, "R7 enabled after reset", int'(wdEnabled), 1);
    check(wdLocked == 1'b0, "R7 unlocked after reset", int'(wdLocked), 0);
    rstN = 1'b1;
    waitPulse(edgesTo(INIT_OFF), "R7 default deadline");
    watchQuiet(CNT_SPAN + 80, "R3 no repeat after timeout");
  endtask

  task automatic t_basic();
    int m;
    doKick(5, m);
    waitPulse(edgesTo(m), "R2 offset 5 timing");
  endtask

  task automatic t_wrap();
    int m;
    while (benchCnt / UNIT != HI_SPAN - 2) idle(1);
    doKick(5, m);
    check(m < 5, "R11 deadline wraps", m, (HI_SPAN - 2 + 5) % HI_SPAN);
    waitPulse(edgesTo(m), "R11 wrapped deadline timing");
  endtask

  task automatic t_zero();
    int m;
    doKick(0, m);
    waitPulse(edgesTo(m), "R5 offset zero full turn");
  endtask

  task automatic t_periodic();
    int m;
    for (int k = 0; k < 20; k++) begin
      doKick(2, m);
      watchQuiet(59, "R4 serviced in time");
    end
    doKick(2, m);
    waitPulse(edgesTo(m), "R4 pulse after service stops");
    watchQuiet(CNT_SPAN + 80, "R4 exactly one pulse");
  endtask

  task automatic t_boundary();
    int m;
    doKick(1, m);
    while (benchCnt % UNIT != UNIT - 1) idle(1);
    doKick(1, m);
    waitPulse(edgesTo(m), "R6 kick on rollover edge wins");
  endtask

  task automatic t_freeze();
    int m;
    doKick(2, m);
    cntEn = 1'b0;
    watchQuiet(400, "R1 frozen counter no timeout");
    cntEn = 1'b1;
    waitPulse(edgesTo(m), "R1 timing resumes with enable");
  endtask

  task automatic t_disable();
    int h, m;
    doCfg(1'b0, 1'b0, h);
    check(wdEnabled == 1'b0, "R8 disabled by mode write", int'(wdEnabled), 0);
    doKick(1, m);
    watchQuiet(CNT_SPAN + 80, "R8 disabled gives no pulse");
    doCfg(1'b1, 1'b0, h);
    check(wdEnabled == 1'b1, "R9 re-enabled", int'(wdEnabled), 1);
    waitPulse(edgesTo((h + INIT_OFF) % HI_SPAN), "R9 re-enable deadline");
  endtask

  task automatic t_lock();
    int h;
    doCfg(1'b0, 1'b0, h);
    check(wdEnabled == 1'b0, "R10 precondition disabled", int'(wdEnabled), 0);
    doCfg(1'b0, 1'b1, h);
    check(wdLocked == 1'b1, "R10 lock set", int'(wdLocked), 1);
    check(wdEnabled == 1'b1, "R10 lock forces enable", int'(wdEnabled), 1);
    waitPulse(edgesTo((h + INIT_OFF) % HI_SPAN), "R10 locked timer expires");
    doCfg(1'b0, 1'b0, h);
    check(wdEnabled == 1'b1, "R10 disable ignored when locked", int'(wdEnabled), 1);
    check(wdLocked == 1'b1, "R10 lock sticky", int'(wdLocked), 1);
    doReset();
    check(wdLocked == 1'b0, "R7 reset clears lock", int'(wdLocked), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_zero();
    t_periodic();
    t_boundary();
    t_freeze();
    t_disable();
    t_lock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule